// File: doc/BRIEF.md
# APS K1/K2 Byte Persistence Filter

This block sits behind the overhead extraction of a line receiver and watches the two automatic protection switching bytes, here called K1 and K2, which arrive once per frame. A received value is not trusted until it has repeated unchanged for three consecutive frames. Once a value passes that test it is written into a 16-bit filtered word, with K2 in the upper byte and K1 in the lower byte. A one-cycle change pulse is raised when the written value differs from the value the word held before.

A sliding-window monitor runs alongside each byte. It raises an unstable alarm when sixteen consecutive frames go by without that byte completing a three-frame identical run. The alarm drops on the first frame that completes such a run. A mode input selects how the bytes are filtered. In split mode each byte is filtered on its own. In joint mode the two bytes are treated as one 16-bit value: both must repeat together before the word updates, and the single change indication appears on the K1 pulse.

Each byte is tracked by a small run-state machine with three states. RS_EMPTY means no frame has been seen since reset. RS_BUILD means a run of one or two identical frames is in progress. RS_HELD means a run of three or more. The transitions are:

- RS_EMPTY goes to RS_BUILD on the first frame.
- RS_BUILD stays in RS_BUILD with the count raised by one on a match.
- RS_BUILD goes to RS_HELD on the match that brings the count to three.
- RS_BUILD restarts its count at one on a mismatch.
- RS_HELD stays in RS_HELD on a match.
- RS_HELD falls back to RS_BUILD, with a count of one, on a mismatch.

Top module: `aps_kbyte_filter`

## Requirements
- R1: While reset is asserted, and after it is released, `filt_word` is 0x0000, both change pulses are 0 and both unstable alarms are 0.
- R2: In split mode (`joint_mode`=0), a K1 value sampled on three consecutive frame strobes is written into `filt_word[7:0]` on the clock edge that samples the third strobe.
- R3: In split mode, K2 is filtered in the same way and independently of K1, and it updates `filt_word[15:8]`.
- R4: A change pulse is high for exactly the one cycle after the accepting edge, and only when the accepted value differs from the one held. Continued repetition of an already accepted value gives no pulse.
- R5: A frame whose byte differs from the byte of the previous frame restarts that byte's persistence count at one. For example, A A B A A does not accept A, and a third following A does.
- R6: Clock cycles without `frame_tick` leave the filtered word, the pulses (held low) and the alarms unchanged, whatever K1, K2 and the mode are.
- R7: In joint mode (`joint_mode`=1), the word updates only when both bytes have each repeated for three consecutive frames. Both bytes then update at once, `k1_chg` is the only change indication, and `k2_chg` stays 0.
- R8: A byte's unstable alarm rises on the frame that completes sixteen consecutive frames, counted from reset or from the last completed run, in none of which that byte ended a run of three identical values.
- R9: An active unstable alarm clears on the frame in which that byte completes, or continues, a run of three identical values.
- R10: The two unstable alarms are computed per byte in both modes. Instability of one byte does not affect the other byte's alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe marking a new K1/K2 sample |
| joint_mode | input | 1 | 1 = K1 and K2 filtered as one 16-bit value |
| k1_in | input | 8 | Received K1 byte, valid with `frame_tick` |
| k2_in | input | 8 | Received K2 byte, valid with `frame_tick` |
| filt_word | output | 16 | Filtered value, K2 in [15:8], K1 in [7:0] |
| k1_chg | output | 1 | K1 change pulse (joint change pulse in joint mode) |
| k2_chg | output | 1 | K2 change pulse (split mode only) |
| k1_unstable | output | 1 | K1 unstable alarm |
| k2_unstable | output | 1 | K2 unstable alarm |

## Verification
Clean three-frame runs in each mode show that acceptance happens on the third frame and that a changed value is told apart from a repeated one. Interrupted runs (A A B A A A), with idle cycles between strobes, separate a proper restart of the count from a count that only pauses or keeps running. In joint mode, a steady K1 against a toggling K2 shows whether a byte is accepted on its own when it should not be. Alternating values held for sixteen and more frames, with one byte steady and the other not, place the alarm's rising frame exactly and show that its clearing follows a completed run and stays per byte.

// File: rtl/aps_filt_pkg.sv
package aps_filt_pkg;

    typedef enum logic [1:0] {
        RS_EMPTY = 2'd0,
        RS_BUILD = 2'd1,
        RS_HELD  = 2'd2
    } run_state_t;

endpackage

// File: rtl/aps_run_tracker.sv
module aps_run_tracker
    import aps_filt_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PERSIST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [BYTE_W-1:0] din,
    output logic              run_ok_nxt
);
    localparam int CW = $clog2(PERSIST + 1);

    run_state_t        state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [BYTE_W-1:0] prev_q;
    logic              same;

    assign same = (din == prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_EMPTY;
            cnt_q   <= '0;
            prev_q  <= '0;
        end else if (tick) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= din;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_EMPTY: begin
                state_d = RS_BUILD;
                cnt_d   = CW'(1);
            end
            RS_BUILD: begin
                if (!same) begin
                    cnt_d = CW'(1);
                end else if (cnt_q == CW'(PERSIST - 1)) begin
                    state_d = RS_HELD;
                    cnt_d   = CW'(PERSIST);
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            RS_HELD: begin
                if (!same) begin
                    state_d = RS_BUILD;
                    cnt_d   = CW'(1);
                end
            end
            default: begin
                state_d = RS_EMPTY;
                cnt_d   = '0;
            end
        endcase
        run_ok_nxt = tick && (state_d == RS_HELD);
    end

endmodule

// File: rtl/aps_window_mon.sv
module aps_window_mon #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run_ok,
    output logic alarm
);
    localparam int GW = $clog2(WINDOW + 1);

    logic [GW-1:0] gap_q, gap_d;

    always_comb begin
        if (run_ok)
            gap_d = '0;
        else if (gap_q == GW'(WINDOW))
            gap_d = gap_q;
        else
            gap_d = gap_q + GW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
            alarm <= 1'b0;
        end else if (tick) begin
            gap_q <= gap_d;
            alarm <= (gap_d == GW'(WINDOW));
        end
    end

endmodule

// File: rtl/aps_kbyte_filter.sv
module aps_kbyte_filter
    import aps_filt_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PERSIST = 3,
    parameter int WINDOW  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_tick,
    input  logic                joint_mode,
    input  logic [BYTE_W-1:0]   k1_in,
    input  logic [BYTE_W-1:0]   k2_in,
    output logic [2*BYTE_W-1:0] filt_word,
    output logic                k1_chg,
    output logic                k2_chg,
    output logic                k1_unstable,
    output logic                k2_unstable
);
    localparam int NCH    = 2;
    localparam int WORD_W = NCH * BYTE_W;

    logic [NCH-1:0][BYTE_W-1:0] byte_in;
    logic [NCH-1:0]             run_ok;
    logic [NCH-1:0]             unstable;

    assign byte_in = {k2_in, k1_in};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        aps_run_tracker #(.BYTE_W(BYTE_W), .PERSIST(PERSIST)) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (frame_tick),
            .din        (byte_in[ch]),
            .run_ok_nxt (run_ok[ch])
        );
        aps_window_mon #(.WINDOW(WINDOW)) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (frame_tick),
            .run_ok (run_ok[ch]),
            .alarm  (unstable[ch])
        );
    end

    assign k1_unstable = unstable[0];
    assign k2_unstable = unstable[1];

    logic [WORD_W-1:0] word_q, word_d;
    logic              chg1_d, chg2_d;
    logic              acc_lo, acc_hi, both_ok;

    always_comb begin
        both_ok = &run_ok;
        acc_lo  = joint_mode ? both_ok : run_ok[0];
        acc_hi  = joint_mode ? both_ok : run_ok[1];
        word_d  = word_q;
        if (acc_lo) word_d[BYTE_W-1:0]      = k1_in;
        if (acc_hi) word_d[WORD_W-1:BYTE_W] = k2_in;
        if (joint_mode) begin
            chg1_d = both_ok && (word_d != word_q);
            chg2_d = 1'b0;
        end else begin
            chg1_d = acc_lo && (k1_in != word_q[BYTE_W-1:0]);
            chg2_d = acc_hi && (k2_in != word_q[WORD_W-1:BYTE_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            k1_chg <= 1'b0;
            k2_chg <= 1'b0;
        end else begin
            word_q <= word_d;
            k1_chg <= chg1_d;
            k2_chg <= chg2_d;
        end
    end

    assign filt_word = word_q;

endmodule

// File: rtl/aps_kbyte_filter_chk.sv
module aps_kbyte_filter_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_tick,
    input logic                joint_mode,
    input logic [2*BYTE_W-1:0] filt_word,
    input logic                k1_chg,
    input logic                k2_chg,
    input logic                k1_unstable,
    input logic                k2_unstable
);

    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(filt_word));

    a_r6_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(k1_unstable) && $stable(k2_unstable)));

    a_r4_k1_single: assert property (@(posedge clk) disable iff (!rst_n)
        k1_chg |=> !k1_chg);

    a_r4_k2_single: assert property (@(posedge clk) disable iff (!rst_n)
        k2_chg |=> !k2_chg);

    a_r4_chg_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (k1_chg || k2_chg) |-> $past(frame_tick));

    a_r4_chg_new_value: assert property (@(posedge clk) disable iff (!rst_n)
        (k1_chg || k2_chg) |-> (filt_word != $past(filt_word)));

    a_r7_joint_k2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (joint_mode && frame_tick) |=> !k2_chg);

endmodule

bind aps_kbyte_filter aps_kbyte_filter_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/test_aps_kbyte_filter.sv
module test_aps_kbyte_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic        joint_mode = 1'b0;
    logic [7:0]  k1_in = 8'h00;
    logic [7:0]  k2_in = 8'h00;
    logic [15:0] filt_word;
    logic        k1_chg, k2_chg, k1_unstable, k2_unstable;

    always #2.5 clk = ~clk;

    aps_kbyte_filter i_aps_kbyte_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_tick  (frame_tick),
        .joint_mode  (joint_mode),
        .k1_in       (k1_in),
        .k2_in       (k2_in),
        .filt_word   (filt_word),
        .k1_chg      (k1_chg),
        .k2_chg      (k2_chg),
        .k1_unstable (k1_unstable),
        .k2_unstable (k2_unstable)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    bit    chk_on   = 0;
    string cur_req  = "R1";

    // behavioural reference: history queues and gap counters
    logic [7:0]  h1[$];
    logic [7:0]  h2[$];
    logic [15:0] m_word = '0;
    bit          m_c1 = 0, m_c2 = 0, m_u1 = 0, m_u2 = 0;
    int          gap1 = 0, gap2 = 0;

    function automatic int tail_run(input logic [7:0] q[$]);
        int n = 0;
        if (q.size() == 0) return 0;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i] == q[q.size() - 1]) n++;
            else break;
        end
        return n;
    endfunction

    always @(posedge clk) begin
        int r1, r2;
        if (!rst_n) begin
            h1.delete(); h2.delete();
            m_word = '0; m_c1 = 0; m_c2 = 0; m_u1 = 0; m_u2 = 0;
            gap1 = 0; gap2 = 0;
        end else begin
            m_c1 = 0; m_c2 = 0;
            if (frame_tick) begin
                h1.push_back(k1_in); if (h1.size() > 3) void'(h1.pop_front());
                h2.push_back(k2_in); if (h2.size() > 3) void'(h2.pop_front());
                r1 = tail_run(h1);
                r2 = tail_run(h2);
                gap1 = (r1 >= 3) ? 0 : ((gap1 < 16) ? gap1 + 1 : 16);
                gap2 = (r2 >= 3) ? 0 : ((gap2 < 16) ? gap2 + 1 : 16);
                m_u1 = (gap1 >= 16);
                m_u2 = (gap2 >= 16);
                if (joint_mode) begin
                    if (r1 >= 3 && r2 >= 3) begin
                        m_c1 = ({k2_in, k1_in} != m_word);
                        m_word = {k2_in, k1_in};
                    end
                end else begin
                    if (r1 >= 3) begin
                        m_c1 = (k1_in != m_word[7:0]);
                        m_word[7:0] = k1_in;
                    end
                    if (r2 >= 3) begin
                        m_c2 = (k2_in != m_word[15:8]);
                        m_word[15:8] = k2_in;
                    end
                end
            end
        end
    end

    task automatic check1(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check1("filt_word",   filt_word,           m_word);
            check1("k1_chg",      {15'd0, k1_chg},      {15'd0, m_c1});
            check1("k2_chg",      {15'd0, k2_chg},      {15'd0, m_c2});
            check1("k1_unstable", {15'd0, k1_unstable}, {15'd0, m_u1});
            check1("k2_unstable", {15'd0, k2_unstable}, {15'd0, m_u2});
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    task automatic frame(input logic [7:0] a, input logic [7:0] b, input int idle);
        @(negedge clk);
        k1_in = a; k2_in = b; frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        k1_in = ~a; k2_in = ~b;  // R6: junk on idle cycles
        repeat (idle) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset values
        cur_req = "R1";
        @(posedge clk);
        chk_on = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: K1 accepted on third identical frame
        cur_req = "R2";
        frame(8'hA1, 8'h00, 0);
        frame(8'hA1, 8'h00, 1);
        frame(8'hA1, 8'h00, 2);

        // R3: K2 filtered independently
        cur_req = "R3";
        frame(8'hA1, 8'h5C, 0);
        frame(8'hA1, 8'h5C, 0);
        frame(8'hA1, 8'h5C, 1);

        // R4: repetition gives no pulse
        cur_req = "R4";
        frame(8'hA1, 8'h5C, 0);
        frame(8'hA1, 8'h5C, 0);

        // R5: interrupted run restarts the count
        cur_req = "R5";
        frame(8'h33, 8'h5C, 0);
        frame(8'h33, 8'h5C, 0);
        frame(8'h44, 8'h5C, 0);
        frame(8'h33, 8'h5C, 0);
        frame(8'h33, 8'h5C, 0);
        frame(8'h33, 8'h5C, 0);

        // R6: long idle stretch with toggling inputs and mode
        cur_req = "R6";
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            k1_in = 8'(i * 17); k2_in = 8'(i * 29); joint_mode = i[0];
        end
        joint_mode = 1'b0;

        // R7: joint mode, K1 steady but K2 toggling: no update
        cur_req = "R7";
        joint_mode = 1'b1;
        frame(8'h77, 8'h01, 0);
        frame(8'h77, 8'h02, 0);
        frame(8'h77, 8'h01, 0);
        frame(8'h77, 8'h02, 0);
        frame(8'h77, 8'h66, 0);
        frame(8'h77, 8'h66, 0);
        frame(8'h77, 8'h66, 0);
        frame(8'h77, 8'h66, 0);
        frame(8'h77, 8'h99, 0);
        frame(8'h77, 8'h99, 0);
        frame(8'h77, 8'h99, 0);
        joint_mode = 1'b0;

        // R8: alarm after 16 frames without a run, counted from reset
        cur_req = "R8";
        do_reset();
        for (int i = 0; i < 20; i++)
            frame(i[0] ? 8'h11 : 8'h22, 8'h40, i % 3);

        // R9: three identical frames clear the alarm
        cur_req = "R9";
        frame(8'h11, 8'h40, 0);
        frame(8'h11, 8'h40, 0);
        frame(8'h11, 8'h40, 1);

        // R10: K2 unstable in joint mode, K1 steady
        cur_req = "R10";
        joint_mode = 1'b1;
        for (int i = 0; i < 18; i++)
            frame(8'h11, 8'(8'h50 + i), 0);
        frame(8'h11, 8'h5A, 0);
        frame(8'h11, 8'h5A, 0);
        frame(8'h11, 8'h5A, 2);
        joint_mode = 1'b0;

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule